// File: doc/BRIEF.md
# Two-Bank Latched Interrupt Aggregator

This block collects sixteen single-cycle event pulses from the rest of the system controller and turns them into one level-sensitive interrupt request toward a host processor. The events are split into two banks of eight. Each bank has a mask register, called enable here, and a latch register, called status here. An event pulse on a source whose enable bit is 1 sets the matching status bit. The bit then stays set until the host clears it.

The host reaches the four registers through a byte-wide register port. This is a flat address, a write strobe with write data, and combinational read data. A status register can only lose bits through a host write. Writing 0 to a bit clears it. Writing 1 leaves it as it was, so software can never set a status bit. The interrupt line is a registered OR of all sixteen status bits. It stays high until the host has cleared every bit in both banks.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, both status registers and both enable registers read 0x00 and `irq_o` is 0.
- R2: Enable registers live at address 11 (bank 0) and address 18 (bank 1). A write stores `reg_wdata` unchanged, and a read in the following cycle returns it.
- R3: An event pulse on `evt_i[i]` whose enable bit is 1 sets the status bit for that source. Bank 0 covers `evt_i[7:0]` and bank 1 covers `evt_i[15:8]`, with bit i of a bank at bit position i. The bit reads as 1 from the cycle after the pulse.
- R4: An event pulse on a source whose enable bit is 0 leaves its status bit at 0.
- R5: A write to a status register changes it to `old & reg_wdata`. A bit written 0 is cleared, and a bit written 1 keeps its old value, so a host write never sets a status bit.
- R6: An enabled event arriving in the same cycle as a write that clears its bit leaves that bit set.
- R7: `irq_o` is active-high. In each cycle it equals the OR of all sixteen status bits as they stood one cycle earlier. It therefore rises one cycle after a bit latches and falls one cycle after the last bit clears.
- R8: Reads of any address other than 10, 11, 17 and 18 return 0x00. Writes to such addresses change no register.
- R9: Status registers live at address 10 (bank 0) and address 17 (bank 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| evt_i | input | 16 | Event pulses. Bits 7:0 feed bank 0 and bits 15:8 feed bank 1 |
| reg_addr | input | 8 | Register address for reads and writes |
| reg_wr | input | 1 | Write strobe, sampled at the clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| irq_o | output | 1 | Level interrupt request to the host |

## Verification
Several properties are checked by assertions on every cycle:
- a status bit never rises without an enabled event in the previous cycle, so no software set is possible;
- a status write leaves exactly the masked value apart from bits an event sets;
- an enabled event always wins over a clearing write;
- `irq_o` follows the OR of the status bits with one cycle of delay;
- at most one register is selected by any address.

Other behaviour is shown only by the bench scenarios. These cover the register address map seen from the port, enable values reading back, unmapped writes leaving every register untouched, and the full sequence from event through clearing to interrupt release across both banks.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned NUM_BANKS = 2;
  localparam int unsigned NUM_SLOTS = 2 * NUM_BANKS;

  // register slots: status of bank b at slot 2b, enable of bank b at slot 2b+1
  typedef enum logic [1:0] {
    SLOT_STAT0 = 2'd0,
    SLOT_EN0   = 2'd1,
    SLOT_STAT1 = 2'd2,
    SLOT_EN1   = 2'd3
  } slot_e;

  function automatic int unsigned stat_slot(input int unsigned bank);
    return 2 * bank;
  endfunction

  function automatic int unsigned en_slot(input int unsigned bank);
    return 2 * bank + 1;
  endfunction
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/irq_bank.sv
module irq_bank #(
  parameter int unsigned BANK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] evt_i,
  input  logic              stat_we,
  input  logic              en_we,
  input  logic [BANK_W-1:0] wdata,
  output logic [BANK_W-1:0] stat_o,
  output logic [BANK_W-1:0] en_o
);
  logic [BANK_W-1:0] stat_q, stat_d;
  logic [BANK_W-1:0] en_q,   en_d;
  logic [BANK_W-1:0] hit;
  logic              stat_ce;

  always_comb begin
    hit     = evt_i & en_q;
    stat_ce = stat_we | (|hit);
    stat_d  = stat_q;
    if (stat_we) stat_d = stat_q & wdata;  // zeros clear, ones hold
    stat_d  = stat_d | hit;                // hardware event has priority
    en_d    = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= '0;
    else if (stat_ce) stat_q <= stat_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_we) en_q <= en_d;
  end

  assign stat_o = stat_q;
  assign en_o   = en_q;

  // assertion support: marks cycles with a valid previous cycle
  logic past_vld_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_vld_q <= 1'b0;
    else        past_vld_q <= 1'b1;
  end

  // R5 / R4: a status bit can only rise through an enabled event
  p_no_sw_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    past_vld_q |-> ((stat_q & ~$past(stat_q) & ~$past(evt_i & en_q)) == '0));

  // R5: a status write leaves old & wdata, apart from event bits
  p_clear_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (past_vld_q && $past(stat_we)) |->
      ((stat_q & ~$past(evt_i & en_q)) == ($past(stat_q & wdata) & ~$past(evt_i & en_q))));

  // R6: an enabled event always leaves its bit set
  p_evt_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_i & en_q)) |=> ((stat_q & $past(evt_i & en_q)) == $past(evt_i & en_q)));

  // R2: enable takes write data
  p_en_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en_we |=> (en_q == $past(wdata)));
endmodule

// File: rtl/irq_regmap.sv
module irq_regmap #(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned BANK_W     = 8,
  parameter int unsigned STAT0_ADDR = 10,
  parameter int unsigned EN0_ADDR   = 11,
  parameter int unsigned STAT1_ADDR = 17,
  parameter int unsigned EN1_ADDR   = 18
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic [ADDR_W-1:0]                          addr,
  input  logic                                       wr,
  input  logic [irq_agg_pkg::NUM_SLOTS-1:0][BANK_W-1:0] regs_i,
  output logic [irq_agg_pkg::NUM_SLOTS-1:0]          we_o,
  output logic [BANK_W-1:0]                          rdata
);
  import irq_agg_pkg::*;

  localparam logic [NUM_SLOTS-1:0][ADDR_W-1:0] SLOT_ADDR = {
    ADDR_W'(EN1_ADDR), ADDR_W'(STAT1_ADDR), ADDR_W'(EN0_ADDR), ADDR_W'(STAT0_ADDR)
  };

  logic [NUM_SLOTS-1:0] sel;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign sel[s]  = (addr == SLOT_ADDR[s]);
    assign we_o[s] = sel[s] & wr;
  end

  always_comb begin
    rdata = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (sel[s]) rdata = rdata | regs_i[s];
    end
  end

  // R8: distinct addresses, so no address selects two registers
  p_sel_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(we_o));

  // R8: unmapped address reads zero
  p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == '0) |-> (rdata == '0));
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int unsigned BANK_W     = 8,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned STAT0_ADDR = 10,
  parameter int unsigned EN0_ADDR   = 11,
  parameter int unsigned STAT1_ADDR = 17,
  parameter int unsigned EN1_ADDR   = 18
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic [irq_agg_pkg::NUM_BANKS*BANK_W-1:0] evt_i,
  input  logic [ADDR_W-1:0]                       reg_addr,
  input  logic                                    reg_wr,
  input  logic [BANK_W-1:0]                       reg_wdata,
  output logic [BANK_W-1:0]                       reg_rdata,
  output logic                                    irq_o
);
  import irq_agg_pkg::*;

  logic                               rst_n_i;
  logic [NUM_SLOTS-1:0]               slot_we;
  logic [NUM_SLOTS-1:0][BANK_W-1:0]   slot_val;
  logic [NUM_BANKS-1:0]               bank_any;
  logic                               any_stat;
  logic                               irq_q, irq_d, irq_ce;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  irq_regmap #(
    .ADDR_W     (ADDR_W),
    .BANK_W     (BANK_W),
    .STAT0_ADDR (STAT0_ADDR),
    .EN0_ADDR   (EN0_ADDR),
    .STAT1_ADDR (STAT1_ADDR),
    .EN1_ADDR   (EN1_ADDR)
  ) u_map (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .addr   (reg_addr),
    .wr     (reg_wr),
    .regs_i (slot_val),
    .we_o   (slot_we),
    .rdata  (reg_rdata)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    irq_bank #(.BANK_W(BANK_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n_i),
      .evt_i   (evt_i[b*BANK_W +: BANK_W]),
      .stat_we (slot_we[stat_slot(b)]),
      .en_we   (slot_we[en_slot(b)]),
      .wdata   (reg_wdata),
      .stat_o  (slot_val[stat_slot(b)]),
      .en_o    (slot_val[en_slot(b)])
    );
    assign bank_any[b] = |slot_val[stat_slot(b)];
  end

  always_comb begin
    any_stat = |bank_any;
    irq_d    = any_stat;
    irq_ce   = (irq_q != any_stat);
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i)    irq_q <= 1'b0;
    else if (irq_ce) irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  logic past_vld_q;
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) past_vld_q <= 1'b0;
    else          past_vld_q <= 1'b1;
  end

  // R7: interrupt is the status OR delayed by one cycle
  p_irq_follow_r7: assert property (@(posedge clk) disable iff (!rst_n_i)
    past_vld_q |-> (irq_o == $past(any_stat)));

  // R7: interrupt holds while any bit is still latched
  p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n_i)
    (irq_o && any_stat) |=> irq_o);
endmodule

// File: tb/tb_irq_aggregator.sv
module tb_irq_aggregator;
  localparam int unsigned A_S0 = 10, A_E0 = 11, A_S1 = 17, A_E1 = 18;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] evt_i;
  logic [7:0]  reg_addr;
  logic        reg_wr;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] m_stat [2];
  logic [7:0] m_en   [2];
  logic       m_irq;

  always #10 clk = ~clk;  // 50 MHz

  irq_aggregator dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (evt_i),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_o     (irq_o)
  );

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    case (a)
      8'(A_S0): return m_stat[0];
      8'(A_E0): return m_en[0];
      8'(A_S1): return m_stat[1];
      8'(A_E1): return m_en[1];
      default:  return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] next_stat(input logic [7:0] old, input logic wsel,
                                           input logic [7:0] d, input logic [7:0] ev,
                                           input logic [7:0] en);
    logic [7:0] r;
    r = wsel ? (old & d) : old;  // R5 write-zero clear
    return r | (ev & en);        // R3/R6 enabled event sets
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd_chk(input logic [7:0] a, input string tag);
    reg_addr = a;
    #1;
    check(tag, reg_rdata, exp_rd(a));
  endtask

  // called at a negedge; returns at the next negedge
  task automatic step(input logic [15:0] ev, input logic wr, input logic [7:0] a,
                      input logic [7:0] d);
    logic [7:0] ns0, ns1;
    evt_i = ev; reg_wr = wr; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    m_irq = (|m_stat[0]) | (|m_stat[1]);
    ns0 = next_stat(m_stat[0], wr && a == 8'(A_S0), d, ev[7:0],  m_en[0]);
    ns1 = next_stat(m_stat[1], wr && a == 8'(A_S1), d, ev[15:8], m_en[1]);
    m_stat[0] = ns0; m_stat[1] = ns1;
    if (wr && a == 8'(A_E0)) m_en[0] = d;
    if (wr && a == 8'(A_E1)) m_en[1] = d;
    @(negedge clk);
    evt_i = '0; reg_wr = 1'b0;
    check("R7 irq", {7'd0, irq_o}, {7'd0, m_irq});
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    evt_i = '0; reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0;
    m_stat[0] = '0; m_stat[1] = '0; m_en[0] = '0; m_en[1] = '0; m_irq = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd_chk(8'(A_S0), "R1 stat0");
    rd_chk(8'(A_E0), "R1 en0");
    rd_chk(8'(A_S1), "R1 stat1");
    rd_chk(8'(A_E1), "R1 en1");
    check("R1 irq", {7'd0, irq_o}, 8'd0);

    // R2 enables
    step('0, 1'b1, 8'(A_E0), 8'h0F);
    step('0, 1'b1, 8'(A_E1), 8'hF0);
    rd_chk(8'(A_E0), "R2 en0 readback");
    rd_chk(8'(A_E1), "R2 en1 readback");

    // R3/R4 bank 0: only enabled low nibble latches
    step(16'h00FF, 1'b0, 8'h00, 8'h00);
    rd_chk(8'(A_S0), "R3 R4 stat0 latch");
    check("R3 stat0 value", reg_rdata, 8'h0F);
    step('0, 1'b0, 8'h00, 8'h00);
    check("R7 irq risen", {7'd0, irq_o}, 8'd1);

    // R9/R4 bank 1 address and masking
    step(16'hA50F & 16'hFF00, 1'b0, 8'h00, 8'h00);
    rd_chk(8'(A_S1), "R9 stat1 addr");
    check("R4 stat1 masked", reg_rdata, 8'hA0);

    // R5 writing ones does not set, zeros clear
    step('0, 1'b1, 8'(A_S0), 8'hFF);
    rd_chk(8'(A_S0), "R5 ones hold");
    check("R5 no set", reg_rdata, 8'h0F);
    step('0, 1'b1, 8'(A_S0), 8'hF5);
    rd_chk(8'(A_S0), "R5 partial clear");
    check("R5 value", reg_rdata, 8'h05);

    // R6 event vs clearing write
    step(16'h0001, 1'b1, 8'(A_S0), 8'h00);
    rd_chk(8'(A_S0), "R6 event wins");
    check("R6 value", reg_rdata, 8'h01);

    // R8 unmapped access
    step('0, 1'b1, 8'd12, 8'hFF);
    step('0, 1'b1, 8'hFF, 8'hFF);
    rd_chk(8'd12, "R8 unmapped read");
    rd_chk(8'hFF, "R8 unmapped read ff");
    rd_chk(8'(A_S0), "R8 stat0 untouched");
    rd_chk(8'(A_E0), "R8 en0 untouched");
    rd_chk(8'(A_S1), "R8 stat1 untouched");
    rd_chk(8'(A_E1), "R8 en1 untouched");

    // R7 release only after both banks clear
    step('0, 1'b1, 8'(A_S0), 8'h00);
    step('0, 1'b0, 8'h00, 8'h00);
    check("R7 held by bank1", {7'd0, irq_o}, 8'd1);
    step('0, 1'b1, 8'(A_S1), 8'h00);
    check("R7 still high one cycle", {7'd0, irq_o}, 8'd1);
    step('0, 1'b0, 8'h00, 8'h00);
    check("R7 dropped", {7'd0, irq_o}, 8'd0);

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [15:0] ev;
      logic        wr;
      logic [7:0]  a, d;
      logic [7:0]  map_addr [5];
      map_addr[0] = 8'(A_S0); map_addr[1] = 8'(A_E0);
      map_addr[2] = 8'(A_S1); map_addr[3] = 8'(A_E1);
      map_addr[4] = 8'($urandom);
      ev = ($urandom % 4 == 0) ? 16'($urandom) : 16'h0;
      wr = ($urandom % 3 == 0);
      a  = map_addr[$urandom % 5];
      d  = 8'($urandom);
      step(ev, wr, a, d);
      rd_chk(map_addr[$urandom % 5], "R3 R5 R8 random read");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule